// File: doc/BRIEF.md
# Transmit Character Skew Buffer

This block is a single-channel elastic buffer that carries transmit characters from a write clock into a local reference clock. Each character is a data byte plus a control/data flag and a word-sync-enable bit, and all three are always stored and delivered together. The two clocks have the same frequency, but the phase between them is unknown and may wander slowly. The buffer takes up this wander without stalling the stream.

Releasing the active-low reset recenters the buffer. The read side waits until the buffer is half full, measured through the pointer synchronizer, and then reads one character on every reference clock edge. If the phase moves far enough that the buffer would run dry, the read side sends the previous character a second time. If the buffer would overfill, the read side skips one character. In both cases a one-cycle error pulse marks the affected output cycle. When the reference clock is selected as the input timing source, the inputs are registered directly on the reference clock, the buffer is bypassed and the error output stays low.

Top module: `tx_skew_buf`

## Requirements
- R1: With a steady phase between the clocks, every written character leaves the block exactly once and in order, with its data byte, control flag and word-sync bit still together in one character.
- R2: While `rst_n` is low, `out_data`, `out_ctl`, `out_wsen` and `slip_err` are 0. After release the outputs stay 0 until the buffer has filled to its centre point, and then one character is delivered per `rd_clk` cycle.
- R3: After a reset, a phase drift of up to half a character period in either direction causes no slip and no error pulse.
- R4: When the writer falls behind far enough to leave the elastic range, the character on the output is held for one extra `rd_clk` cycle, so the same character appears twice. `slip_err` is 1 in the cycle that shows the repeat.
- R5: When the writer runs ahead far enough to leave the elastic range, one character never reaches the output. `slip_err` is 1 in the cycle that shows the character after the missing one.
- R6: `slip_err` is high only in cycles where the output is a repeat or follows a skipped character. Each pulse is one `rd_clk` cycle wide and stands for exactly one slip.
- R7: With `ref_timing` = 1 (reference-clock timing), the outputs equal the inputs sampled at the previous `rd_clk` rising edge and `slip_err` stays 0, even while the write clock drifts.
- R8: A reset that follows slips recenters the buffer, so that a later steady stream runs without slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock that times the input characters |
| rd_clk | input | 1 | Local reference clock that times the outputs |
| rst_n | input | 1 | Asynchronous active-low reset that recenters the buffer |
| ref_timing | input | 1 | 1 = inputs timed to `rd_clk` and buffer bypassed, 0 = inputs timed to `wr_clk` |
| in_data | input | DATA_W | Data byte of the input character |
| in_ctl | input | 1 | Control/data flag of the input character |
| in_wsen | input | 1 | Word-sync-enable bit of the input character |
| out_data | output | DATA_W | Data byte of the output character |
| out_ctl | output | 1 | Control/data flag of the output character |
| out_wsen | output | 1 | Word-sync-enable bit of the output character |
| slip_err | output | 1 | Registered one-cycle pulse for each repeated or dropped character |

## Verification
The assertions assume that the two clocks are frequency-locked and that the phase moves by much less than one character per cycle. Under that assumption the synchronized occupancy can never jump past the margin that remains above the skip threshold. They also assume that `ref_timing` changes only while the bypass inputs are timed to `rd_clk`. The stimulus keeps within these limits. The write-clock period differs from the read period by at most 0.5 %, and only for a limited number of cycles. In bypass mode the bench drives the inputs on falling `rd_clk` edges.

// File: rtl/skb_pkg.sv
`timescale 1ns/1ps
package skb_pkg;

   // Smallest synchronizer depth considered safe for pointer crossing.
   localparam int unsigned SKB_MIN_SYNC = 2;

   // Safety distance between the skip threshold and a full buffer.
   localparam int unsigned SKB_GUARD = 2;

   // Action taken by the read side on one reference clock edge.
   typedef enum logic [1:0] {
      SLIP_NONE   = 2'd0,
      SLIP_REPEAT = 2'd1,
      SLIP_SKIP   = 2'd2
   } skb_slip_e;

endpackage

// File: rtl/skb_rst_sync.sv
`timescale 1ns/1ps
module skb_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);

   logic [STAGES-1:0] sh_q;

   // Assertion is asynchronous; deassertion is synchronous to clk.
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         sh_q <= '0;
      end else begin
         sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
   end

   assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/skb_gray_sync.sv
`timescale 1ns/1ps
module skb_gray_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg_q;

   // Gray input: each stage sees at most one changing bit per source step.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d};
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/skb_wr_side.sv
`timescale 1ns/1ps
module skb_wr_side #(
   parameter int unsigned CHAR_W = 10,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned AW     = 4,
   parameter int unsigned PTR_W  = 5
) (
   input  logic              wr_clk,
   input  logic              wrst_n,
   input  logic [CHAR_W-1:0] wr_char,
   input  logic [AW-1:0]     rd_addr_a,
   input  logic [AW-1:0]     rd_addr_b,
   output logic [CHAR_W-1:0] rd_char_a,
   output logic [CHAR_W-1:0] rd_char_b,
   output logic [PTR_W-1:0]  wr_gray
);

   logic [CHAR_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q;
   logic [PTR_W-1:0]  wr_ptr_nxt;
   logic [PTR_W-1:0]  wr_gray_q;

   function automatic logic [PTR_W-1:0] bin_to_gray(input logic [PTR_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   assign wr_ptr_nxt = wr_ptr_q + PTR_W'(1);

   // A character is written on every write clock once reset has released.
   always_ff @(posedge wr_clk) begin
      if (wrst_n) begin
         mem_q[wr_ptr_q[AW-1:0]] <= wr_char;
      end
   end

   // The Gray copy is registered, so the crossing sees a glitch-free count.
   always_ff @(posedge wr_clk or negedge wrst_n) begin
      if (!wrst_n) begin
         wr_ptr_q  <= '0;
         wr_gray_q <= '0;
      end else begin
         wr_ptr_q  <= wr_ptr_nxt;
         wr_gray_q <= bin_to_gray(wr_ptr_nxt);
      end
   end

   assign rd_char_a = mem_q[rd_addr_a];
   assign rd_char_b = mem_q[rd_addr_b];
   assign wr_gray   = wr_gray_q;

endmodule

// File: rtl/skb_rd_side.sv
`timescale 1ns/1ps
module skb_rd_side
   import skb_pkg::*;
#(
   parameter int unsigned CHAR_W = 10,
   parameter int unsigned AW     = 4,
   parameter int unsigned PTR_W  = 5,
   parameter int unsigned CENTER = 6,
   parameter int unsigned LO     = 4,
   parameter int unsigned HI     = 9
) (
   input  logic              rd_clk,
   input  logic              rrst_n,
   input  logic [PTR_W-1:0]  wq_gray,
   output logic [AW-1:0]     rd_addr_a,
   output logic [AW-1:0]     rd_addr_b,
   input  logic [CHAR_W-1:0] rd_char_a,
   input  logic [CHAR_W-1:0] rd_char_b,
   output logic [CHAR_W-1:0] out_char,
   output logic              slip,
   output logic              running,
   output logic [PTR_W-1:0]  occ
);

   localparam logic [PTR_W-1:0] CENTER_P = PTR_W'(CENTER);
   localparam logic [PTR_W-1:0] LO_P     = PTR_W'(LO);
   localparam logic [PTR_W-1:0] HI_P     = PTR_W'(HI);

   logic [PTR_W-1:0]  rd_ptr_q;
   logic [PTR_W-1:0]  wq_bin;
   logic [CHAR_W-1:0] out_q;
   logic              slip_q;
   logic              run_q;
   skb_slip_e         action;

   function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
      logic [PTR_W-1:0] b;
      b[PTR_W-1] = g[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

   assign wq_bin    = gray_to_bin(wq_gray);
   assign occ       = wq_bin - rd_ptr_q;
   assign rd_addr_a = rd_ptr_q[AW-1:0];
   assign rd_addr_b = rd_ptr_q[AW-1:0] + AW'(1);

   // Slip decision from the measured fill level.
   always_comb begin
      if (occ <= LO_P) begin
         action = SLIP_REPEAT;
      end else if (occ >= HI_P) begin
         action = SLIP_SKIP;
      end else begin
         action = SLIP_NONE;
      end
   end

   always_ff @(posedge rd_clk or negedge rrst_n) begin
      if (!rrst_n) begin
         rd_ptr_q <= '0;
         out_q    <= '0;
         slip_q   <= 1'b0;
         run_q    <= 1'b0;
      end else if (!run_q) begin
         slip_q <= 1'b0;
         if (occ >= CENTER_P) begin
            run_q <= 1'b1;
         end
      end else begin
         unique case (action)
            SLIP_REPEAT: begin
               slip_q <= 1'b1;
            end
            SLIP_SKIP: begin
               out_q    <= rd_char_b;
               rd_ptr_q <= rd_ptr_q + PTR_W'(2);
               slip_q   <= 1'b1;
            end
            default: begin
               out_q    <= rd_char_a;
               rd_ptr_q <= rd_ptr_q + PTR_W'(1);
               slip_q   <= 1'b0;
            end
         endcase
      end
   end

   assign out_char = out_q;
   assign slip     = slip_q;
   assign running  = run_q;

endmodule

// File: rtl/tx_skew_buf.sv
`timescale 1ns/1ps
module tx_skew_buf
   import skb_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned DEPTH         = 16,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          ENABLE_BYPASS = 1'b1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              ref_timing,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_ctl,
   input  logic              in_wsen,
   output logic [DATA_W-1:0] out_data,
   output logic              out_ctl,
   output logic              out_wsen,
   output logic              slip_err
);

   localparam int unsigned CHAR_W = DATA_W + 2;
   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned PTR_W  = AW + 1;
   localparam int unsigned CENTER = DEPTH / 2 - SYNC_STAGES;
   localparam int unsigned LO     = CENTER - 2;
   localparam int unsigned HI     = CENTER + 3;

   // Elaboration-time parameter checks.
   if (DATA_W < 1) begin : g_bad_width
      $error("tx_skew_buf: DATA_W must be at least 1");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_pow2
      $error("tx_skew_buf: DEPTH must be a power of two");
   end
   if (SYNC_STAGES < SKB_MIN_SYNC) begin : g_bad_sync
      $error("tx_skew_buf: SYNC_STAGES below safe minimum");
   end
   if (CENTER < 2) begin : g_bad_center
      $error("tx_skew_buf: DEPTH too small for the synchronizer lag");
   end
   if (HI + SYNC_STAGES + SKB_GUARD + 1 >= DEPTH) begin : g_bad_margin
      $error("tx_skew_buf: skip threshold leaves no overfill margin");
   end

   logic              wrst_n;
   logic              rrst_n;
   logic [CHAR_W-1:0] wr_char;
   logic [PTR_W-1:0]  wr_gray_q;
   logic [PTR_W-1:0]  wq_gray;
   logic [AW-1:0]     rd_addr_a;
   logic [AW-1:0]     rd_addr_b;
   logic [CHAR_W-1:0] char_a;
   logic [CHAR_W-1:0] char_b;
   logic [CHAR_W-1:0] fifo_char;
   logic              fifo_slip;
   logic              rd_running;
   logic [PTR_W-1:0]  rd_occ;
   logic [CHAR_W-1:0] out_char;

   assign wr_char = {in_data, in_ctl, in_wsen};

   skb_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
      .clk    (wr_clk),
      .arst_n (rst_n),
      .srst_n (wrst_n)
   );

   skb_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
      .clk    (rd_clk),
      .arst_n (rst_n),
      .srst_n (rrst_n)
   );

   skb_wr_side #(
      .CHAR_W (CHAR_W),
      .DEPTH  (DEPTH),
      .AW     (AW),
      .PTR_W  (PTR_W)
   ) u_wr (
      .wr_clk    (wr_clk),
      .wrst_n    (wrst_n),
      .wr_char   (wr_char),
      .rd_addr_a (rd_addr_a),
      .rd_addr_b (rd_addr_b),
      .rd_char_a (char_a),
      .rd_char_b (char_b),
      .wr_gray   (wr_gray_q)
   );

   skb_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
      .clk   (rd_clk),
      .rst_n (rrst_n),
      .d     (wr_gray_q),
      .q     (wq_gray)
   );

   skb_rd_side #(
      .CHAR_W (CHAR_W),
      .AW     (AW),
      .PTR_W  (PTR_W),
      .CENTER (CENTER),
      .LO     (LO),
      .HI     (HI)
   ) u_rd (
      .rd_clk    (rd_clk),
      .rrst_n    (rrst_n),
      .wq_gray   (wq_gray),
      .rd_addr_a (rd_addr_a),
      .rd_addr_b (rd_addr_b),
      .rd_char_a (char_a),
      .rd_char_b (char_b),
      .out_char  (fifo_char),
      .slip      (fifo_slip),
      .running   (rd_running),
      .occ       (rd_occ)
   );

   // Variant choice: reference-clock timing path present or not.
   if (ENABLE_BYPASS) begin : g_bypass
      logic [CHAR_W-1:0] byp_q;
      logic              ref_q;

      always_ff @(posedge rd_clk or negedge rrst_n) begin
         if (!rrst_n) begin
            byp_q <= '0;
            ref_q <= 1'b0;
         end else begin
            byp_q <= wr_char;
            ref_q <= ref_timing;
         end
      end

      assign out_char = ref_q ? byp_q : fifo_char;
      assign slip_err = fifo_slip & ~ref_q;
   end else begin : g_direct
      assign out_char = fifo_char;
      assign slip_err = fifo_slip;
   end

   assign {out_data, out_ctl, out_wsen} = out_char;

endmodule

// File: rtl/tx_skew_buf_chk.sv
`timescale 1ns/1ps
module tx_skew_buf_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned PTR_W = 5,
   parameter int unsigned LO    = 4,
   parameter int unsigned HI    = 9
) (
   input logic             wr_clk,
   input logic             rd_clk,
   input logic             rst_n,
   input logic             ref_timing,
   input logic             slip_err,
   input logic             running,
   input logic [PTR_W-1:0] occ,
   input logic [PTR_W-1:0] wr_gray
);

   localparam logic [PTR_W-1:0] LO_P     = PTR_W'(LO);
   localparam logic [PTR_W-1:0] HI_P     = PTR_W'(HI);
   localparam logic [PTR_W-1:0] OCC_MAX  = PTR_W'(DEPTH - 4);

   // R1: the write count crosses domains one Gray bit at a time
   assert_gray_step_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(wr_gray ^ $past(wr_gray)));

   // R7: reference-clock timing never reports a slip
   assert_no_err_bypass_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $past(ref_timing) |-> !slip_err);

   // R6: an error pulse follows a fill level outside the elastic range
   assert_err_cause_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      slip_err |-> (($past(occ) <= LO_P) || ($past(occ) >= HI_P)));

   // R2: no error before the read side has started after recentering
   assert_err_running_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
      slip_err |-> running);

   // R5: the measured fill never approaches a full buffer
   assert_no_overflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      running |-> (occ <= OCC_MAX));

endmodule

bind tx_skew_buf tx_skew_buf_chk #(
   .DEPTH (DEPTH),
   .PTR_W (PTR_W),
   .LO    (LO),
   .HI    (HI)
) u_chk (
   .wr_clk     (wr_clk),
   .rd_clk     (rd_clk),
   .rst_n      (rst_n),
   .ref_timing (ref_timing),
   .slip_err   (slip_err),
   .running    (rd_running),
   .occ        (rd_occ),
   .wr_gray    (wr_gray_q)
);

// File: tb/tx_skew_buf_test.sv
`timescale 1ns/1ps
module tx_skew_buf_test;

   localparam real CLK_PERIOD = 10.0;
   localparam real HALF       = CLK_PERIOD / 2.0;

   logic       wr_clk;
   logic       rd_clk;
   logic       rst_n;
   logic       ref_timing;
   logic [7:0] in_data;
   logic       in_ctl;
   logic       in_wsen;
   logic [7:0] out_data;
   logic       out_ctl;
   logic       out_wsen;
   logic       slip_err;

   real        wr_step = 0.0;
   bit         wr_drive_en = 1'b1;
   logic [7:0] seq = 8'd1;

   int checks = 0;
   int failures = 0;

   bit         mon_en = 1'b0;
   bit         m_started;
   logic [7:0] m_prev;
   int         m_rep, m_skip, m_err, m_bad, m_ok;

   tx_skew_buf uut (
      .wr_clk     (wr_clk),
      .rd_clk     (rd_clk),
      .rst_n      (rst_n),
      .ref_timing (ref_timing),
      .in_data    (in_data),
      .in_ctl     (in_ctl),
      .in_wsen    (in_wsen),
      .out_data   (out_data),
      .out_ctl    (out_ctl),
      .out_wsen   (out_wsen),
      .slip_err   (slip_err)
   );

   initial begin
      rd_clk = 1'b0;
      forever #(HALF) rd_clk = ~rd_clk;
   end

   // Write clock: fixed phase offset, each low phase stretched by wr_step.
   initial begin
      wr_clk = 1'b0;
      #3.3;
      forever begin
         wr_clk = 1'b1;
         #(HALF);
         wr_clk = 1'b0;
         #(HALF + wr_step);
      end
   end

   // Character source in the write domain; flags derived from the byte.
   initial begin
      in_data = 8'd0;
      in_ctl  = 1'b0;
      in_wsen = 1'b0;
      forever begin
         @(negedge wr_clk);
         if (wr_drive_en) begin
            in_data <= seq;
            in_ctl  <= seq[0];
            in_wsen <= seq[2] ^ seq[5];
            seq     <= seq + 8'd1;
         end
      end
   end

   // Stream monitor: classifies every output step (R1, R4, R5, R6).
   initial begin
      logic [7:0] diff;
      forever begin
         @(negedge rd_clk);
         if (mon_en) begin
            if (!m_started) begin
               if (out_data != 8'd0) begin
                  m_started = 1'b1;
                  m_prev    = out_data;
                  if (slip_err) m_bad++;
               end
            end else begin
               diff = out_data - m_prev;
               if (out_ctl != out_data[0] || out_wsen != (out_data[2] ^ out_data[5])) m_bad++;
               if (diff == 8'd1 && !slip_err) m_ok++;
               else if (diff == 8'd0 && slip_err) m_rep++;
               else if (diff == 8'd2 && slip_err) m_skip++;
               else m_bad++;
               if (slip_err) m_err++;
               m_prev = out_data;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      m_started = 1'b0;
      m_prev = 8'd0;
      m_rep = 0; m_skip = 0; m_err = 0; m_bad = 0; m_ok = 0;
   endtask

   // Reset with checks of the reset state (R2).
   task automatic do_reset(input bit check_state);
      mon_en = 1'b0;
      @(negedge rd_clk);
      rst_n = 1'b0;
      repeat (4) @(negedge rd_clk);
      if (check_state) begin
         check(out_data == 8'd0 && !out_ctl && !out_wsen, "R2", "outputs in reset",
               int'({out_data, out_ctl, out_wsen}), 0);
         check(!slip_err, "R2", "slip_err in reset", int'(slip_err), 0);
      end
      clear_mon();
      rst_n = 1'b1;
      mon_en = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset(1'b1);
      repeat (2) @(negedge rd_clk);
      check(out_data == 8'd0 && !slip_err, "R2", "held at zero while filling",
            int'(out_data), 0);
      repeat (40) @(negedge rd_clk);
      check(m_started, "R2", "stream started after fill", int'(m_started), 1);
   endtask

   task automatic t_steady();
      wr_step = 0.0;
      do_reset(1'b0);
      repeat (800) @(negedge rd_clk);
      check(m_bad == 0, "R1", "order/field errors steady", m_bad, 0);
      check(m_err == 0, "R1", "error pulses steady", m_err, 0);
      check(m_ok > 700, "R1", "in-order characters", m_ok, 700);
   endtask

   // Drift of 500 * step ns, half a character at |step| = 0.01 (R3).
   task automatic t_tolerance(input real step);
      wr_step = 0.0;
      do_reset(1'b0);
      repeat (30) @(negedge rd_clk);
      wr_step = step;
      repeat (500) @(negedge rd_clk);
      wr_step = 0.0;
      repeat (300) @(negedge rd_clk);
      check(m_err == 0, "R3", "error pulses within half char", m_err, 0);
      check(m_bad == 0, "R3", "order errors within half char", m_bad, 0);
   endtask

   task automatic t_underrun();
      wr_step = 0.0;
      do_reset(1'b0);
      repeat (30) @(negedge rd_clk);
      wr_step = 0.05;
      repeat (2000) @(negedge rd_clk);
      wr_step = 0.0;
      repeat (20) @(negedge rd_clk);
      check(m_rep >= 4 && m_rep <= 10, "R4", "repeat count", m_rep, 7);
      check(m_skip == 0, "R4", "no skips when writer slow", m_skip, 0);
      check(m_bad == 0 && m_err == m_rep, "R6", "pulse per repeat", m_err, m_rep);
   endtask

   task automatic t_overrun();
      wr_step = 0.0;
      do_reset(1'b0);
      repeat (30) @(negedge rd_clk);
      wr_step = -0.05;
      repeat (2000) @(negedge rd_clk);
      wr_step = 0.0;
      repeat (20) @(negedge rd_clk);
      check(m_skip >= 4 && m_skip <= 10, "R5", "skip count", m_skip, 7);
      check(m_rep == 0, "R5", "no repeats when writer fast", m_rep, 0);
      check(m_bad == 0 && m_err == m_skip, "R6", "pulse per skip", m_err, m_skip);
   endtask

   // Reset right after slips, then a steady stream (R8).
   task automatic t_recenter();
      wr_step = 0.0;
      do_reset(1'b1);
      repeat (600) @(negedge rd_clk);
      check(m_err == 0, "R8", "error pulses after recenter", m_err, 0);
      check(m_bad == 0 && m_started, "R8", "stream after recenter", m_bad, 0);
   endtask

   // Reference-clock timing: inputs driven on rd_clk falling edges (R7).
   task automatic t_bypass();
      int errs = 0;
      int miss = 0;
      mon_en = 1'b0;
      wr_drive_en = 1'b0;
      @(negedge rd_clk);
      wr_step = 0.05;
      ref_timing = 1'b1;
      repeat (2) @(negedge rd_clk);
      for (int k = 0; k < 300; k++) begin
         logic [7:0] v;
         v = 8'(k * 37 + 5);
         in_data = v;
         in_ctl  = v[3];
         in_wsen = ~v[6];
         @(negedge rd_clk);
         if (out_data != v || out_ctl != v[3] || out_wsen != ~v[6]) miss++;
         if (slip_err) errs++;
      end
      check(miss == 0, "R7", "pass-through mismatches", miss, 0);
      check(errs == 0, "R7", "error pulses in bypass", errs, 0);
      wr_step = 0.0;
   endtask

   initial begin
      rst_n = 1'b1;
      ref_timing = 1'b0;
      clear_mon();
      t_reset_state();
      t_steady();
      t_tolerance(0.01);
      t_tolerance(-0.01);
      t_underrun();
      t_overrun();
      t_recenter();
      t_bypass();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000.0);
      checks++;
      failures++;
      $display("FAIL watchdog all actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule